// File: doc/BRIEF.md
# Write-Masked Lane Control Register Bank

This block is a small set of 16-bit control registers behind a single-cycle write/read port, used to steer a four-lane receive PHY. Every 32-bit write word carries its own bit-enable: bit `16+k` of the word lets bit `k` of the addressed register take bit `k` of the word. Any bit whose enable is clear keeps its old value. Software can therefore change one field of a shared register without first reading it back.

Three registers can be written. The lane register drives the per-lane enable, forced receive mode, forced stop state and turnaround-disable controls. The turnaround register drives the turnaround requests and two clock-invert selects. The test port register drives the byte-wide test interface strobes. A fourth, read-only address returns the PHY's test output byte. Reads are combinational from the address. A write to any address that has no writable register raises a one-cycle error pulse and changes nothing.

Top module: `lane_ctl_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every writable bit is cleared, so all field outputs and all register reads return zero, and `wr_err` is low.
- R2: On a write, register bit k changes to `wdata[k]` only when `wdata[16+k]` is 1. When `wdata[16+k]` is 0, bit k keeps its previous value.
- R3: Lane register at address 0: bits [3:0] drive `lane_en`, [7:4] drive `frc_rx`, [11:8] drive `frc_stop` and [15:12] drive `turn_off`.
- R4: Turnaround register at address 1: bits [3:0] drive `turn_req`, bit 10 drives `clk_inv[0]` and bit 11 drives `clk_inv[1]`. Its other bits cannot be set and read as zero.
- R5: Test port register at address 2: bits [7:0] drive `tst_din`, bit 8 drives `tst_en`, bit 9 drives `tst_clk` and bit 10 drives `tst_clr`. Bits [15:11] cannot be set and read as zero.
- R6: Address 3 reads `tst_dout` in bits [7:0] and zero above. A write to it is treated as unmapped (R8).
- R7: `rdata` bits [31:16] are always zero. Unmapped addresses (4 and above) read all zero.
- R8: A write to address 3 or above leaves every register unchanged, and `wr_err` is high for exactly the cycle after that write's clock edge.
- R9: `wr_err` is low in the cycle after an edge with no write, or with a write to address 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| addr | input | 3 | Register address for write and read |
| wdata | input | 32 | Bit enables in [31:16], data in [15:0] |
| rdata | output | 32 | Read data for `addr`, upper half zero |
| wr_err | output | 1 | One-cycle pulse after a write to an unwritable address |
| tst_dout | input | 8 | Test output byte from the PHY |
| lane_en | output | 4 | Per-lane enable |
| frc_rx | output | 4 | Per-lane forced receive mode |
| frc_stop | output | 4 | Per-lane forced stop state |
| turn_off | output | 4 | Per-lane turnaround disable |
| turn_req | output | 4 | Per-lane turnaround request |
| clk_inv | output | 2 | Clock invert selects |
| tst_din | output | 8 | Test interface data byte |
| tst_en | output | 1 | Test interface enable |
| tst_clk | output | 1 | Test interface clock level |
| tst_clr | output | 1 | Test interface clear |

## Verification
The hardest case to reach is a write whose enable half only partly covers a field. Such a write must merge old and new bits inside one 4-bit or 8-bit field, and only on lines where the stored value and the written data differ. Directed writes first load known patterns. Then a seeded random run sends several hundred writes with independent random enable and data halves across all eight addresses. This produces many partial-field merges on top of varied prior contents. It also produces back-to-back unmapped writes, where the error pulse must be high in consecutive cycles.

// File: rtl/lane_ctl_bank.sv
module lane_ctl_bank #(
  parameter int AW = 3,
  parameter int RW = 16,
  parameter int LANES = 4,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [2*RW-1:0] wdata,
  output logic [2*RW-1:0] rdata,
  output logic          wr_err,
  input  logic [TW-1:0] tst_dout,
  output logic [LANES-1:0] lane_en,
  output logic [LANES-1:0] frc_rx,
  output logic [LANES-1:0] frc_stop,
  output logic [LANES-1:0] turn_off,
  output logic [LANES-1:0] turn_req,
  output logic [1:0]    clk_inv,
  output logic [TW-1:0] tst_din,
  output logic          tst_en,
  output logic          tst_clk,
  output logic          tst_clr
);
  localparam logic [AW-1:0] A_LANE = AW'(0);
  localparam logic [AW-1:0] A_TURN = AW'(1);
  localparam logic [AW-1:0] A_TEST = AW'(2);
  localparam logic [AW-1:0] A_STAT = AW'(3);
  localparam logic [RW-1:0] IMP_LANE = {RW{1'b1}};
  localparam logic [RW-1:0] IMP_TURN = RW'(16'h0C0F);
  localparam logic [RW-1:0] IMP_TEST = RW'((1 << (TW + 3)) - 1);

  logic [RW-1:0] r_lane, r_turn, r_test;
  logic [RW-1:0] en_bits, dat_bits;
  logic          hit_lane, hit_turn, hit_test;

  assign en_bits  = wdata[2*RW-1:RW];
  assign dat_bits = wdata[RW-1:0];
  assign hit_lane = wr_en && (addr == A_LANE);
  assign hit_turn = wr_en && (addr == A_TURN);
  assign hit_test = wr_en && (addr == A_TEST);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_lane <= '0;
      r_turn <= '0;
      r_test <= '0;
      wr_err <= 1'b0;
    end else begin
      if (hit_lane) r_lane <= (r_lane & ~(en_bits & IMP_LANE)) | (dat_bits & en_bits & IMP_LANE);
      if (hit_turn) r_turn <= (r_turn & ~(en_bits & IMP_TURN)) | (dat_bits & en_bits & IMP_TURN);
      if (hit_test) r_test <= (r_test & ~(en_bits & IMP_TEST)) | (dat_bits & en_bits & IMP_TEST);
      wr_err <= wr_en && !(hit_lane || hit_turn || hit_test);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_LANE:  rdata[RW-1:0] = r_lane;
      A_TURN:  rdata[RW-1:0] = r_turn;
      A_TEST:  rdata[RW-1:0] = r_test;
      A_STAT:  rdata[TW-1:0] = tst_dout;
      default: rdata = '0;
    endcase
  end

  assign lane_en  = r_lane[LANES-1:0];
  assign frc_rx   = r_lane[2*LANES-1:LANES];
  assign frc_stop = r_lane[3*LANES-1:2*LANES];
  assign turn_off = r_lane[4*LANES-1:3*LANES];
  assign turn_req = r_turn[LANES-1:0];
  assign clk_inv  = r_turn[11:10];
  assign tst_din  = r_test[TW-1:0];
  assign tst_en   = r_test[TW];
  assign tst_clk  = r_test[TW+1];
  assign tst_clr  = r_test[TW+2];

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (r_lane == '0 && r_turn == '0 && r_test == '0 && !wr_err));

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hit_lane |=> ((r_lane ^ $past(r_lane)) & ~$past(en_bits)) == '0);

  // R8
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr >= A_STAT) |=> ($stable(r_lane) && $stable(r_turn) && $stable(r_test)));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || addr < A_STAT) |=> !wr_err);
endmodule

// File: tb/tb_lane_ctl_bank.sv
module tb_lane_ctl_bank;
  logic        clk = 1'b0;
  logic        rst, wr_en;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata;
  logic        wr_err;
  logic [7:0]  tst_dout, tst_din;
  logic [3:0]  lane_en, frc_rx, frc_stop, turn_off, turn_req;
  logic [1:0]  clk_inv;
  logic        tst_en, tst_clk, tst_clr;

  int n_chk = 0, n_bad = 0;
  logic [15:0] m_lane = 0, m_turn = 0, m_test = 0;

  always #2.5 clk = ~clk;

  lane_ctl_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wr_err(wr_err), .tst_dout(tst_dout),
    .lane_en(lane_en), .frc_rx(frc_rx), .frc_stop(frc_stop), .turn_off(turn_off),
    .turn_req(turn_req), .clk_inv(clk_inv), .tst_din(tst_din),
    .tst_en(tst_en), .tst_clk(tst_clk), .tst_clr(tst_clr)
  );

  function automatic logic [15:0] merge(logic [15:0] old, logic [31:0] w, logic [15:0] imp);
    logic [15:0] e;
    e = w[31:16] & imp;
    return (old & ~e) | (w[15:0] & e);
  endfunction

  function automatic logic [31:0] exp_read(logic [2:0] a, logic [7:0] st);
    case (a)
      3'd0: return {16'h0, m_lane};
      3'd1: return {16'h0, m_turn};
      3'd2: return {16'h0, m_test};
      3'd3: return {24'h0, st};
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [2:0] a, logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = w;
    case (a)
      3'd0: m_lane = merge(m_lane, w, 16'hFFFF);
      3'd1: m_turn = merge(m_turn, w, 16'h0C0F);
      3'd2: m_test = merge(m_test, w, 16'h07FF);
      default: ;
    endcase
    @(posedge clk);
    #1 wr_en = 1'b0;
    check(a >= 3 ? "R8" : "R9", {31'h0, wr_err}, {31'h0, (a >= 3)});
  endtask

  task automatic check_fields(string req);
    check(req, {16'h0, turn_off, frc_stop, frc_rx, lane_en}, {16'h0, m_lane});
    check(req, {16'h0, 4'h0, clk_inv, 6'h0, turn_req}, {16'h0, m_turn});
    check(req, {16'h0, 5'h0, tst_clr, tst_clk, tst_en, tst_din}, {16'h0, m_test});
  endtask

  task automatic read_chk(string req, logic [2:0] a);
    addr = a;
    #0.2 check(req, rdata, exp_read(a, tst_dout));
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; wr_en = 1'b0; addr = 0; wdata = 0; tst_dout = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1 reset state
    check("R1", {31'h0, wr_err}, 32'h0);
    check_fields("R1");
    for (int a = 0; a < 3; a++) read_chk("R1", 3'(a));

    // R3 lane layout
    do_write(3'd0, 32'hFFFF_A5C3);
    check("R3", {16'h0, turn_off, frc_stop, frc_rx, lane_en}, 32'h0000_A5C3);
    check("R3", {28'h0, frc_rx}, 32'hC);
    // R2 partial enable: clear frc_rx only
    do_write(3'd0, 32'h00F0_0000);
    check("R2", {16'h0, turn_off, frc_stop, frc_rx, lane_en}, 32'h0000_A503);
    // R2 enable clear: nothing moves
    do_write(3'd0, 32'h0000_FFFF);
    read_chk("R2", 3'd0);
    check("R2", {16'h0, turn_off, frc_stop, frc_rx, lane_en}, 32'h0000_A503);

    // R4 turn register
    do_write(3'd1, 32'hFFFF_FFFF);
    read_chk("R4", 3'd1);
    check("R4", {26'h0, clk_inv, turn_req}, 32'h3F);
    do_write(3'd1, 32'h0400_0000);
    check("R4", {30'h0, clk_inv}, 32'h2);

    // R5 test register
    do_write(3'd2, 32'hFFFF_FFFF);
    read_chk("R5", 3'd2);
    check("R5", {21'h0, tst_clr, tst_clk, tst_en, tst_din}, 32'h7FF);
    do_write(3'd2, 32'h0200_0000);
    check("R5", {29'h0, tst_clr, tst_clk, tst_en}, 32'h5);

    // R6 status read and write to it
    tst_dout = 8'h5A;
    read_chk("R6", 3'd3);
    do_write(3'd3, 32'hFFFF_0000);
    check_fields("R6");
    read_chk("R6", 3'd3);

    // R8 unmapped write, then R9 pulse ends
    do_write(3'd5, 32'hFFFF_0000);
    check_fields("R8");
    @(posedge clk); #1;
    check("R9", {31'h0, wr_err}, 32'h0);
    // R7 unmapped reads
    read_chk("R7", 3'd6);
    read_chk("R7", 3'd7);

    // random mix, R2 R7 R8 R9
    for (int i = 0; i < 400; i++) begin
      logic [2:0] a;
      a = 3'($urandom_range(0, 7));
      tst_dout = 8'($urandom);
      do_write(a, $urandom);
      check_fields("R2");
      read_chk("R7", a);
    end

    // R1 reset clears again
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    m_lane = 0; m_turn = 0; m_test = 0;
    check_fields("R1");
    check("R1", {31'h0, wr_err}, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule